// File: doc/BRIEF.md
# Masked Data Address Watchpoint Unit

This block watches the data-memory access stream of a processor pipeline and raises a per-watchpoint hit flag in the same cycle as the access strobe, so the pipeline can stop the access before it changes memory. It holds a parameterised number of watchpoints (one or two). Each watchpoint has a base address register and a control register. The control register arms the watchpoint for loads, for stores or for both, and carries a small mask field that sets how many low address bits the compare ignores.

The unit always cleans up the mask field when the control register is written, so the watched window is always a power-of-two sized region aligned to its own size. The field is scanned from its top bit downward. The run of ones up to the first zero is kept, and every bit below that zero is cleared. A field of all ones watches exactly one byte. A field of all zeros watches a 64-byte block. Address bits above the field always take part in the compare. Software writes the registers through a one-word configuration port. The hit vector goes to the debug logic, which raises the exception itself.

Top module: `dbk_unit`

## Requirements
- R1: After synchronous reset every watchpoint is disarmed, and `hit` stays 0 for any access until a control write arms a watchpoint.
- R2: A write with `cfg_we`=1 goes to watchpoint `cfg_idx`. With `cfg_is_ctrl`=0 it loads the base address, and with `cfg_is_ctrl`=1 it loads the control register. The write takes effect from the next clock edge, and the other watchpoint is left unchanged.
- R3: Control bit 31 arms the watchpoint for stores (`acc_is_store`=1) and control bit 30 arms it for loads (`acc_is_store`=0). With neither bit set, the watchpoint never hits.
- R4: `hit` is combinational from the access inputs in the strobe cycle itself, and it is 0 in any cycle with `acc_valid`=0.
- R5: Address bits 31:6 of the access must equal the base address bits exactly for a hit.
- R6: Control bits 5:0 form the mask field. A field made of k ones from bit 5 downward followed by zeros ignores the low 6-k address bits. The result is an aligned region of 2^(6-k) bytes that contains the base.
- R7: A field that is not of that form is truncated at its first zero counted from bit 5. For example, 6'b110101 behaves exactly like 6'b110000 (a 16-byte region).
- R8: Mask field 6'b111111 matches one byte exactly. Mask field 6'b000000 matches the whole 64-byte block.
- R9: `hit` has one bit per watchpoint (bit i for watchpoint i), and the bits are computed independently, so several can be set in the same cycle.
- R10: Control bits 29:6 have no effect on matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_is_ctrl | input | 1 | 1 selects the control register, 0 selects the base address |
| cfg_idx | input | IDX_W | Watchpoint selected by the write |
| cfg_wdata | input | ADDR_W | Write data |
| acc_valid | input | 1 | Data access strobe |
| acc_is_store | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | ADDR_W | Byte address of the access |
| hit | output | NUM_PAIRS | Per-watchpoint hit flags, valid in the strobe cycle |

## Verification
The bench goes after the region edges: the last byte inside a window and the first byte past it, for the single-byte and the 64-byte settings. An off-by-one in the mask would let one of them through or lose the other. It writes non-contiguous mask fields and accesses an address that differs from the base only in a bit the raw field would still compare, so a design that skipped the truncation misses that access. It checks the direction arming and the unused control bits. It also checks that two watchpoints hit at once, that a write to one leaves the other alone, and that a hit at the same edge as the strobe is not delayed by a cycle. Seeded random programming and accesses near each base cover the rest against a bench model.

// File: rtl/dbk_pkg.sv
package dbk_pkg;
  // Direction of a data access as seen on acc_is_store
  typedef enum logic {
    ACC_LOAD  = 1'b0,
    ACC_STORE = 1'b1
  } acc_dir_e;
endpackage

// File: rtl/dbk_mask_norm.sv
// Keeps the leading run of ones of the mask field and clears every bit
// from the first zero downward, giving an aligned power-of-two window.
module dbk_mask_norm #(
  parameter int MASK_W = 6
) (
  input  logic [MASK_W-1:0] field_in,
  output logic [MASK_W-1:0] field_out
);
  int  lead;
  logic run;

  always_comb begin
    lead = 0;
    run  = 1'b1;
    for (int i = MASK_W - 1; i >= 0; i--) begin
      if (run && field_in[i]) lead = lead + 1;
      else run = 1'b0;
    end
    for (int i = 0; i < MASK_W; i++) begin
      field_out[i] = (i >= MASK_W - lead);
    end
  end
endmodule

// File: rtl/dbk_pair.sv
module dbk_pair
  import dbk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MASK_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_base,
  input  logic              wr_ctrl,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              acc_valid,
  input  logic              acc_is_store,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              hit
);
  localparam int ST_BIT = ADDR_W - 1;
  localparam int LD_BIT = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q;
  logic [MASK_W-1:0] field_q;
  logic [MASK_W-1:0] field_n;
  logic              ld_q, st_q;
  logic [ADDR_W-1:0] cmp_mask;
  logic              dir_ok;
  logic              unused_ctrl_bits;

  assign unused_ctrl_bits = ^wdata[LD_BIT-1:MASK_W];

  dbk_mask_norm #(.MASK_W(MASK_W)) u_norm (
    .field_in  (wdata[MASK_W-1:0]),
    .field_out (field_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      field_q <= '1;
      ld_q    <= 1'b0;
      st_q    <= 1'b0;
    end else begin
      if (wr_base) base_q <= wdata;
      if (wr_ctrl) begin
        field_q <= field_n;
        ld_q    <= wdata[LD_BIT];
        st_q    <= wdata[ST_BIT];
      end
    end
  end

  assign cmp_mask = {{(ADDR_W-MASK_W){1'b1}}, field_q};
  assign dir_ok   = (acc_dir_e'(acc_is_store) == ACC_STORE) ? st_q : ld_q;
  assign hit      = acc_valid && dir_ok && (((acc_addr ^ base_q) & cmp_mask) == '0);
endmodule

// File: rtl/dbk_unit.sv
module dbk_unit #(
  parameter int ADDR_W    = 32,
  parameter int MASK_W    = 6,
  parameter int NUM_PAIRS = 2,
  localparam int IDX_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic                 cfg_is_ctrl,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [ADDR_W-1:0]    cfg_wdata,
  input  logic                 acc_valid,
  input  logic                 acc_is_store,
  input  logic [ADDR_W-1:0]    acc_addr,
  output logic [NUM_PAIRS-1:0] hit
);
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic sel;
    assign sel = cfg_we && (cfg_idx == IDX_W'(p));
    dbk_pair #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_pair (
      .clk          (clk),
      .rst          (rst),
      .wr_base      (sel && !cfg_is_ctrl),
      .wr_ctrl      (sel && cfg_is_ctrl),
      .wdata        (cfg_wdata),
      .acc_valid    (acc_valid),
      .acc_is_store (acc_is_store),
      .acc_addr     (acc_addr),
      .hit          (hit[p])
    );
  end
endmodule

// File: rtl/dbk_unit_chk.sv
module dbk_unit_chk #(
  parameter int ADDR_W    = 32,
  parameter int MASK_W    = 6,
  parameter int NUM_PAIRS = 2,
  parameter int IDX_W     = 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cfg_we,
  input logic                 cfg_is_ctrl,
  input logic [IDX_W-1:0]     cfg_idx,
  input logic [ADDR_W-1:0]    cfg_wdata,
  input logic                 acc_valid,
  input logic                 acc_is_store,
  input logic [ADDR_W-1:0]    acc_addr,
  input logic [NUM_PAIRS-1:0] hit
);
  // R4
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |-> acc_valid);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hit == '0));

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_chk
    logic              sh_ld, sh_st;
    logic [ADDR_W-1:0] sh_base;
    always_ff @(posedge clk) begin
      if (rst) begin
        sh_ld   <= 1'b0;
        sh_st   <= 1'b0;
        sh_base <= '0;
      end else if (cfg_we && cfg_idx == IDX_W'(p)) begin
        if (cfg_is_ctrl) begin
          sh_st <= cfg_wdata[ADDR_W-1];
          sh_ld <= cfg_wdata[ADDR_W-2];
        end else begin
          sh_base <= cfg_wdata;
        end
      end
    end

    // R3
    store_arm_chk: assert property (@(posedge clk) disable iff (rst)
      (hit[p] && acc_is_store) |-> sh_st);

    // R3
    load_arm_chk: assert property (@(posedge clk) disable iff (rst)
      (hit[p] && !acc_is_store) |-> sh_ld);

    // R5
    upper_match_chk: assert property (@(posedge clk) disable iff (rst)
      hit[p] |-> (acc_addr[ADDR_W-1:MASK_W] == sh_base[ADDR_W-1:MASK_W]));
  end
endmodule

bind dbk_unit dbk_unit_chk #(
  .ADDR_W(ADDR_W), .MASK_W(MASK_W), .NUM_PAIRS(NUM_PAIRS), .IDX_W(IDX_W)
) u_dbk_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_is_ctrl(cfg_is_ctrl),
  .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
  .acc_is_store(acc_is_store), .acc_addr(acc_addr), .hit(hit)
);

// File: tb/test_dbk_unit.sv
module test_dbk_unit;
  localparam int NP = 2;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we, cfg_is_ctrl;
  logic [0:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic        acc_valid, acc_is_store;
  logic [31:0] acc_addr;
  logic [1:0]  hit;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_base [NP];
  logic [31:0] m_ctrl [NP];

  always #2 clk = ~clk;

  dbk_unit #(.ADDR_W(32), .MASK_W(6), .NUM_PAIRS(NP)) i_dbk_unit (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_is_ctrl(cfg_is_ctrl),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
    .acc_is_store(acc_is_store), .acc_addr(acc_addr), .hit(hit)
  );

  // Number of low address bits ignored: position of the first zero
  // from bit 5 downward, plus one; none if the field is all ones.
  function automatic int ignored_bits(input logic [5:0] f);
    for (int k = 5; k >= 0; k--) if (!f[k]) return k + 1;
    return 0;
  endfunction

  function automatic logic [1:0] model_hit(input logic v, input logic st, input logic [31:0] a);
    logic [1:0] r = '0;
    for (int p = 0; p < NP; p++) begin
      int  ib  = ignored_bits(m_ctrl[p][5:0]);
      logic en = st ? m_ctrl[p][31] : m_ctrl[p][30];
      if (v && en && (((a ^ m_base[p]) >> ib) == 0)) r[p] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: hit=%b expected %b", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int p, input logic is_ctrl, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_is_ctrl = is_ctrl; cfg_idx = 1'(p); cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    if (is_ctrl) m_ctrl[p] = d; else m_base[p] = d;
  endtask

  // Applies an access and samples the hit in the same cycle.
  task automatic access(input string req, input logic v, input logic st, input logic [31:0] a,
                        input logic [1:0] exp);
    @(negedge clk);
    acc_valid = v; acc_is_store = st; acc_addr = a;
    #1;
    check(req, hit, exp);
    if (exp !== model_hit(v, st, a)) $display("bench model disagrees with directed value for %s", req);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; cfg_we = 0; cfg_is_ctrl = 0; cfg_idx = 0; cfg_wdata = 0;
    acc_valid = 0; acc_is_store = 0; acc_addr = 0;
    for (int p = 0; p < NP; p++) begin m_base[p] = 0; m_ctrl[p] = 32'h0000_003F; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: disarmed after reset, address 0 matches the reset base
    access("R1 reset load", 1, 0, 32'h0, 2'b00);
    access("R1 reset store", 1, 1, 32'h0, 2'b00);

    // Pair 0: 16-byte window, stores only
    cfg_write(0, 0, 32'h1000_0040);
    cfg_write(0, 1, 32'h8000_0030);
    access("R6 store inside top", 1, 1, 32'h1000_004F, 2'b01);
    access("R6 store past end", 1, 1, 32'h1000_0050, 2'b00);
    access("R3 load not armed", 1, 0, 32'h1000_0040, 2'b00);
    access("R4 no strobe", 0, 1, 32'h1000_0040, 2'b00);
    access("R5 upper bit differs", 1, 1, 32'h9000_0040, 2'b00);

    // R7: 110101 truncates to 110000; bit 2 differs from base
    cfg_write(0, 1, 32'hC000_0035);
    access("R7 truncated mask load", 1, 0, 32'h1000_0044, 2'b01);
    access("R7 truncated mask store", 1, 1, 32'h1000_004B, 2'b01);

    // R8: exact byte and 64-byte block
    cfg_write(1, 0, 32'h2000_0000);
    cfg_write(1, 1, 32'h4000_0000);
    access("R8 field zero last byte", 1, 0, 32'h2000_003F, 2'b10);
    access("R8 field zero past block", 1, 0, 32'h2000_0040, 2'b00);
    access("R3 pair1 store disarmed", 1, 1, 32'h2000_0010, 2'b00);
    cfg_write(1, 1, 32'h4000_003F);
    access("R8 exact byte", 1, 0, 32'h2000_0000, 2'b10);
    access("R8 exact neighbour", 1, 0, 32'h2000_0001, 2'b00);

    // R10: middle control bits set change nothing
    cfg_write(1, 1, 32'h7FFF_FFC0);
    access("R10 middle bits", 1, 0, 32'h2000_0021, 2'b10);

    // R9 / R2: both pairs in the same window, independent writes
    cfg_write(1, 0, 32'h1000_0048);
    cfg_write(1, 1, 32'hC000_0038);
    access("R9 both hit", 1, 1, 32'h1000_0049, 2'b11);
    access("R9 only pair0", 1, 1, 32'h1000_0042, 2'b01);
    cfg_write(0, 1, 32'h0000_0030);
    access("R2 R3 pair0 disarmed pair1 kept", 1, 0, 32'h1000_004A, 2'b10);

    // R2 timing: a control write is not visible in its own cycle
    @(negedge clk);
    cfg_we = 1; cfg_is_ctrl = 1; cfg_idx = 0; cfg_wdata = 32'hC000_0030;
    acc_valid = 1; acc_is_store = 0; acc_addr = 32'h1000_0040;
    #1; check("R2 write not yet visible", hit, 2'b00);
    @(posedge clk); #1;
    check("R2 write visible next edge", hit, 2'b01);
    @(negedge clk); cfg_we = 0; m_ctrl[0] = 32'hC000_0030;

    // Random programming and accesses near each base
    for (int it = 0; it < 300; it++) begin
      int p = $urandom_range(0, NP - 1);
      if ($urandom_range(0, 1) == 1) cfg_write(p, 0, $urandom());
      else cfg_write(p, 1, $urandom());
      for (int k = 0; k < 4; k++) begin
        logic [31:0] a;
        logic st = 1'($urandom_range(0, 1));
        int q = $urandom_range(0, NP - 1);
        a = ($urandom_range(0, 7) == 0) ? $urandom() : (m_base[q] ^ ($urandom() & 32'h7F));
        @(negedge clk);
        acc_valid = 1; acc_is_store = st; acc_addr = a;
        #1;
        check("R5 R6 R7 R9 random", hit, model_hit(1'b1, st, a));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule